// File: doc/BRIEF.md
# Power-on Reset and Clock Ramp Sequencer

This block sequences a processor core from the moment its supplies come up to normal running, and back down again for sleep or reset. It selects the divisor pair that the clock generator uses. Power-up holds the slowest pair (16/32) while the supplies and the power-good indication settle. The pair then steps to 2/4 and to 1/2, and each step is held for a fixed number of clock cycles by a shared dwell timer. After the ramp, the sequencer starts the on-chip self-initialization phase and then the self-test phase, waiting on each done input. It then waits for the clock-forward reset to be released, holds one more timed step, and enters the running state.

From the running state, a sleep request or an asserted chip reset walks the divisor pair back through 1/2, 2/4 and 16/32, again one timed step each. The sequencer then parks in a wait-for-interrupt state (sleep) or a wait-for-reset-release state (reset). Either exit restarts the ramp-up. A fault seen while running parks the sequencer in a fault state. Recovery from the fault ramps the clock up again but skips self-initialization and self-test. The chip reset and power-good inputs are asynchronous and pass through synchronizers. Loss of either supply returns the sequencer to its cold state.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `seq_state` is 0 (cold), the divisor pair is 16/32, and `init_start`, `init_run`, `test_start` and `test_run` are all 0. The state codes are: cold 0, settle 1, nominal 2, ramp-slow 3, ramp-full 4, init-wait 5, test-wait 6, forward-hold 7, forward-timed 8, run 9, down-full 10, down-mid 11, down-slow 12, irq-wait 13, reset-wait 14, fault 15.
- R2: Cold moves to settle on the next clock edge once both supply inputs are high and the synchronized chip reset is asserted (low). Settle moves to nominal on the third clock edge after `pwr_good` rises, because `pwr_good` passes through a two-stage synchronizer.
- R3: The divisor pair (`div_x`/`div_z`) follows the state:
  - 2/4 in ramp-slow and down-mid.
  - 1/2 in ramp-full, init-wait, test-wait, forward-hold, forward-timed, run and down-full.
  - 16/32 in every other state.
- R4: Nominal moves to ramp-slow on the third clock edge after `sys_reset_n` rises. Ramp-slow and ramp-full each last exactly DWELL cycles (default 4108).
- R5: Leaving ramp-full after a normal start enters init-wait.
  - `init_start` is high for the first cycle of init-wait only, and `init_run` is high for the whole of init-wait.
  - `init_done` moves init-wait to test-wait on the next edge. `test_start` and `test_run` behave in test-wait the same way.
  - `test_done` moves test-wait to forward-hold on the next edge.
- R6: Forward-hold waits for `fwd_rst` to be low and then moves to forward-timed on the next edge. Forward-timed lasts exactly DWELL cycles and then enters run.
- R7: In run, `sleep_req` high or the synchronized chip reset asserted moves to down-full. The chip-reset path takes effect on the third edge after `sys_reset_n` falls. Down-full, down-mid and down-slow each last exactly DWELL cycles, in that order.
- R8: When down-slow ends, the sequencer enters irq-wait if `sleep_req` is high and reset-wait otherwise.
- R9: In irq-wait, `irq` high moves to ramp-slow on the next edge. In reset-wait, `sys_reset_n` high moves to ramp-slow on the third edge. Either wake repeats the full ramp, including init-wait and test-wait.
- R10: In run, `fault` high moves to fault on the next edge and takes priority over sleep and reset. Fault moves to ramp-slow once `fault` is low and the synchronized chip reset is released. That recovery goes from ramp-full directly to forward-hold, with no `init_start` or `test_start` pulse.
- R11: If `pll_pwr_ok` or `core_pwr_ok` is low, the state is cold after the next clock edge, from any state.
- R12: In cold with a supply missing, `irq`, `init_done`, `test_done`, `sleep_req`, `fault` and `fwd_rst` have no effect: the state stays 0, the divisor pair stays 16/32 and no start pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| sys_reset_n | input | 1 | Asynchronous chip reset, low = asserted |
| pll_pwr_ok | input | 1 | Clock-generator supply present |
| core_pwr_ok | input | 1 | Core supply present |
| pwr_good | input | 1 | Asynchronous power-good indication |
| fwd_rst | input | 1 | Clock-forward reset, high = held in reset |
| init_done | input | 1 | Self-initialization finished |
| test_done | input | 1 | Self-test finished |
| sleep_req | input | 1 | Sleep request |
| irq | input | 1 | Enabled interrupt pending |
| fault | input | 1 | Fault reset request |
| seq_state | output | 4 | Current state code |
| div_x | output | 5 | First divisor of the clock-generator pair |
| div_z | output | 6 | Second divisor of the clock-generator pair |
| init_start | output | 1 | One-cycle start of self-initialization |
| init_run | output | 1 | Self-initialization phase active |
| test_start | output | 1 | One-cycle start of self-test |
| test_run | output | 1 | Self-test phase active |

## Verification
Some properties are checked on every cycle:
- Every timed step, up or down, lasts exactly DWELL cycles before it hands over.
- Ramp-slow, run and down-slow leave only to their permitted successors.
- A fault in run always wins over sleep and reset.
- Loss of a supply reaches cold one edge later.
- Each start pulse lasts one cycle, inside its phase.

Only the bench's scenarios can show certain end-to-end behaviours:
- The full order of states and divisor pairs across a sleep cycle, a reset cycle and a fault recovery.
- The three-edge synchronizer latency on the asynchronous inputs.
- The choice between irq-wait and reset-wait.
- The absence of self-test pulses after a fault.

// File: rtl/pwrup_seq_pkg.sv
// Shared types for the power-up sequencer: state codes, divisor pair,
// and per-state helpers. Assumes 16 states fit a 4-bit code.
package pwrup_seq_pkg;

    localparam int DIVX_W = 5;
    localparam int DIVZ_W = 6;

    typedef enum logic [3:0] {
        ST_COLD       = 4'd0,
        ST_SETTLE     = 4'd1,
        ST_NOMINAL    = 4'd2,
        ST_RAMP_SLOW  = 4'd3,
        ST_RAMP_FULL  = 4'd4,
        ST_INIT_WAIT  = 4'd5,
        ST_TEST_WAIT  = 4'd6,
        ST_FWD_HOLD   = 4'd7,
        ST_FWD_TIMED  = 4'd8,
        ST_RUN        = 4'd9,
        ST_DOWN_FULL  = 4'd10,
        ST_DOWN_MID   = 4'd11,
        ST_DOWN_SLOW  = 4'd12,
        ST_IRQ_WAIT   = 4'd13,
        ST_RESET_WAIT = 4'd14,
        ST_FAULT      = 4'd15
    } seq_state_e;

    typedef struct packed {
        logic [DIVX_W-1:0] x;
        logic [DIVZ_W-1:0] z;
    } div_pair_t;

    // Divisor pair the clock generator uses in each state
    function automatic div_pair_t div_of(seq_state_e s);
        div_pair_t d;
        case (s)
            ST_RAMP_SLOW, ST_DOWN_MID: begin
                d.x = DIVX_W'(2);
                d.z = DIVZ_W'(4);
            end
            ST_RAMP_FULL, ST_INIT_WAIT, ST_TEST_WAIT, ST_FWD_HOLD,
            ST_FWD_TIMED, ST_RUN, ST_DOWN_FULL: begin
                d.x = DIVX_W'(1);
                d.z = DIVZ_W'(2);
            end
            default: begin
                d.x = DIVX_W'(16);
                d.z = DIVZ_W'(32);
            end
        endcase
        return d;
    endfunction

    // States whose length is set by the dwell timer
    function automatic logic is_timed(seq_state_e s);
        return (s == ST_RAMP_SLOW) || (s == ST_RAMP_FULL) || (s == ST_FWD_TIMED) ||
               (s == ST_DOWN_FULL) || (s == ST_DOWN_MID)  || (s == ST_DOWN_SLOW);
    endfunction

endpackage

// File: rtl/pwrup_sync.sv
// Multi-stage synchronizer for one asynchronous level.
// Assumes STAGES >= 2; the output takes RST_VAL during block reset.
module pwrup_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwrup_dwell_timer.sv
// Down-counter that times one sequencer step. A load sets it to DWELL-1;
// done is high while the count is zero, so a step lasts DWELL cycles.
// Assumes DWELL >= 2.
module pwrup_dwell_timer #(
    parameter int DWELL = 4108
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = $clog2(DWELL);
    localparam logic [CW-1:0] LOAD_VAL = CW'(DWELL - 1);

    logic [CW-1:0] cnt;

    // Reload on step entry, otherwise count down to zero and hold
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= LOAD_VAL;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwrup_seq.sv
// Power-up / power-down sequencer. Steps the clock divisor pair through
// slow, intermediate and full speed and back, runs the self-init and
// self-test phases, and handles sleep, reset and fault paths.
// Assumes init_done, test_done, fwd_rst, sleep_req, irq and fault are
// synchronous to clk; sys_reset_n and pwr_good may be asynchronous.
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int DWELL       = 4108,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset_n,
    input  logic              pll_pwr_ok,
    input  logic              core_pwr_ok,
    input  logic              pwr_good,
    input  logic              fwd_rst,
    input  logic              init_done,
    input  logic              test_done,
    input  logic              sleep_req,
    input  logic              irq,
    input  logic              fault,
    output logic [3:0]        seq_state,
    output logic [DIVX_W-1:0] div_x,
    output logic [DIVZ_W-1:0] div_z,
    output logic              init_start,
    output logic              init_run,
    output logic              test_start,
    output logic              test_run
);
    seq_state_e state_q, state_d;
    logic       chip_rst_n_s, pg_s;
    logic       step_done, step_load;
    logic       skip_selftest_q;
    logic       pwr_ok;
    div_pair_t  div_now;

    pwrup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rst (
        .clk(clk), .rst_n(rst_n), .d(sys_reset_n), .q(chip_rst_n_s));

    pwrup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_pg (
        .clk(clk), .rst_n(rst_n), .d(pwr_good), .q(pg_s));

    pwrup_dwell_timer #(.DWELL(DWELL)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(step_load), .done(step_done));

    assign pwr_ok    = pll_pwr_ok & core_pwr_ok;
    assign step_load = is_timed(state_d) && (state_d != state_q);

    // Next-state selection; supply loss overrides every state
    always_comb begin
        state_d = state_q;
        if (!pwr_ok) begin
            state_d = ST_COLD;
        end else begin
            case (state_q)
                ST_COLD:       if (!chip_rst_n_s) state_d = ST_SETTLE;
                ST_SETTLE:     if (pg_s)          state_d = ST_NOMINAL;
                ST_NOMINAL:    if (chip_rst_n_s)  state_d = ST_RAMP_SLOW;
                ST_RAMP_SLOW:  if (step_done)     state_d = ST_RAMP_FULL;
                ST_RAMP_FULL:  if (step_done)
                                   state_d = skip_selftest_q ? ST_FWD_HOLD : ST_INIT_WAIT;
                ST_INIT_WAIT:  if (init_done)     state_d = ST_TEST_WAIT;
                ST_TEST_WAIT:  if (test_done)     state_d = ST_FWD_HOLD;
                ST_FWD_HOLD:   if (!fwd_rst)      state_d = ST_FWD_TIMED;
                ST_FWD_TIMED:  if (step_done)     state_d = ST_RUN;
                ST_RUN: begin
                    if (fault)                           state_d = ST_FAULT;
                    else if (sleep_req || !chip_rst_n_s) state_d = ST_DOWN_FULL;
                end
                ST_DOWN_FULL:  if (step_done)     state_d = ST_DOWN_MID;
                ST_DOWN_MID:   if (step_done)     state_d = ST_DOWN_SLOW;
                ST_DOWN_SLOW:  if (step_done)
                                   state_d = sleep_req ? ST_IRQ_WAIT : ST_RESET_WAIT;
                ST_IRQ_WAIT:   if (irq)           state_d = ST_RAMP_SLOW;
                ST_RESET_WAIT: if (chip_rst_n_s)  state_d = ST_RAMP_SLOW;
                ST_FAULT:      if (!fault && chip_rst_n_s) state_d = ST_RAMP_SLOW;
                default:                          state_d = ST_COLD;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_COLD;
        else        state_q <= state_d;
    end

    // Remember a fault recovery until the ramp reaches the forward-reset hold
    always_ff @(posedge clk) begin
        if (!rst_n || state_d == ST_COLD || state_d == ST_FWD_HOLD)
            skip_selftest_q <= 1'b0;
        else if (state_q == ST_FAULT && state_d == ST_RAMP_SLOW)
            skip_selftest_q <= 1'b1;
    end

    // One-cycle start pulses on entry to the self-init and self-test waits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_start <= 1'b0;
            test_start <= 1'b0;
        end else begin
            init_start <= (state_d == ST_INIT_WAIT) && (state_q != ST_INIT_WAIT);
            test_start <= (state_d == ST_TEST_WAIT) && (state_q != ST_TEST_WAIT);
        end
    end

    assign div_now   = div_of(state_q);
    assign div_x     = div_now.x;
    assign div_z     = div_now.z;
    assign init_run  = (state_q == ST_INIT_WAIT);
    assign test_run  = (state_q == ST_TEST_WAIT);
    assign seq_state = state_q;
endmodule

// File: rtl/pwrup_seq_chk.sv
// Property checker for pwrup_seq, attached by bind. Observes ports only
// and keeps its own run-length counter to check timed-step durations.
module pwrup_seq_chk
    import pwrup_seq_pkg::*;
#(
    parameter int DWELL = 4108
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pll_pwr_ok,
    input logic       core_pwr_ok,
    input logic       fault,
    input logic [3:0] seq_state,
    input logic       init_start,
    input logic       init_run,
    input logic       test_start,
    input logic       test_run
);
    localparam int RW = $clog2(DWELL + 2) + 1;

    logic [3:0]    last_st;
    logic [RW-1:0] run_len;

    // Track the previous state and how many cycles it has lasted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_st <= 4'd0;
            run_len <= '0;
        end else begin
            last_st <= seq_state;
            run_len <= (seq_state != last_st) ? RW'(1) : run_len + 1'b1;
        end
    end

    // R4 R6 R7: a timed step hands over only after exactly DWELL cycles
    a_r4_timed_dwell: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != last_st && is_timed(seq_state_e'(last_st)) && seq_state != 4'd0)
        |-> (run_len == RW'(DWELL)));

    a_r4_ramp_slow_next: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd3) |=> (seq_state == 4'd3 || seq_state == 4'd4 || seq_state == 4'd0));

    a_r7_run_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd9) |=>
        (seq_state == 4'd9 || seq_state == 4'd10 || seq_state == 4'd15 || seq_state == 4'd0));

    a_r8_down_slow_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd12) |=>
        (seq_state == 4'd12 || seq_state == 4'd13 || seq_state == 4'd14 || seq_state == 4'd0));

    a_r10_fault_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state == 4'd9 && fault && pll_pwr_ok && core_pwr_ok) |=> (seq_state == 4'd15));

    a_r11_power_loss: assert property (@(posedge clk) disable iff (!rst_n)
        !(pll_pwr_ok && core_pwr_ok) |=> (seq_state == 4'd0));

    a_r5_init_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        init_start |-> (init_run && !$past(init_run)));

    a_r5_test_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        test_start |-> (test_run && !$past(test_run)));
endmodule

bind pwrup_seq pwrup_seq_chk #(.DWELL(DWELL)) u_chk (
    .clk(clk), .rst_n(rst_n), .pll_pwr_ok(pll_pwr_ok), .core_pwr_ok(core_pwr_ok),
    .fault(fault), .seq_state(seq_state), .init_start(init_start),
    .init_run(init_run), .test_start(test_start), .test_run(test_run));

// File: tb/pwrup_seq_test.sv
module pwrup_seq_test;
    localparam int DWELL = 4108;
    localparam logic [15:0] D = 16'(DWELL);

    localparam logic [3:0] C_COLD = 0, C_SETTLE = 1, C_NOM = 2, C_RS = 3, C_RF = 4,
                           C_INIT = 5, C_TEST = 6, C_FH = 7, C_FT = 8, C_RUN = 9,
                           C_DF = 10, C_DM = 11, C_DS = 12, C_IRQW = 13, C_RSTW = 14,
                           C_FLT = 15;
    localparam logic [3:0] A_NONE = 0, A_PWR = 1, A_PG = 2, A_RELS = 3, A_INIT = 4,
                           A_TEST = 5, A_FWD = 6, A_SLEEP = 7, A_IRQ = 8, A_RSTDN = 9,
                           A_FLT = 10, A_FLTCLR = 11;
    localparam int NE = 38;

    // {state, div_x, div_z, action, cycles in state (0 = not measured)}
    localparam logic [34:0] TBL [0:NE-1] = '{
        {C_COLD,   5'd16, 6'd32, A_PWR,   16'd1},
        {C_SETTLE, 5'd16, 6'd32, A_PG,    16'd3},
        {C_NOM,    5'd16, 6'd32, A_RELS,  16'd3},
        {C_RS,     5'd2,  6'd4,  A_NONE,  D},
        {C_RF,     5'd1,  6'd2,  A_NONE,  D},
        {C_INIT,   5'd1,  6'd2,  A_INIT,  16'd1},
        {C_TEST,   5'd1,  6'd2,  A_TEST,  16'd1},
        {C_FH,     5'd1,  6'd2,  A_FWD,   16'd1},
        {C_FT,     5'd1,  6'd2,  A_NONE,  D},
        {C_RUN,    5'd1,  6'd2,  A_SLEEP, 16'd1},
        {C_DF,     5'd1,  6'd2,  A_NONE,  D},
        {C_DM,     5'd2,  6'd4,  A_NONE,  D},
        {C_DS,     5'd16, 6'd32, A_NONE,  D},
        {C_IRQW,   5'd16, 6'd32, A_IRQ,   16'd1},
        {C_RS,     5'd2,  6'd4,  A_NONE,  D},
        {C_RF,     5'd1,  6'd2,  A_NONE,  D},
        {C_INIT,   5'd1,  6'd2,  A_INIT,  16'd1},
        {C_TEST,   5'd1,  6'd2,  A_TEST,  16'd1},
        {C_FH,     5'd1,  6'd2,  A_NONE,  16'd1},
        {C_FT,     5'd1,  6'd2,  A_NONE,  D},
        {C_RUN,    5'd1,  6'd2,  A_RSTDN, 16'd3},
        {C_DF,     5'd1,  6'd2,  A_NONE,  D},
        {C_DM,     5'd2,  6'd4,  A_NONE,  D},
        {C_DS,     5'd16, 6'd32, A_NONE,  D},
        {C_RSTW,   5'd16, 6'd32, A_RELS,  16'd3},
        {C_RS,     5'd2,  6'd4,  A_NONE,  D},
        {C_RF,     5'd1,  6'd2,  A_NONE,  D},
        {C_INIT,   5'd1,  6'd2,  A_INIT,  16'd1},
        {C_TEST,   5'd1,  6'd2,  A_TEST,  16'd1},
        {C_FH,     5'd1,  6'd2,  A_NONE,  16'd1},
        {C_FT,     5'd1,  6'd2,  A_NONE,  D},
        {C_RUN,    5'd1,  6'd2,  A_FLT,   16'd1},
        {C_FLT,    5'd16, 6'd32, A_FLTCLR,16'd1},
        {C_RS,     5'd2,  6'd4,  A_NONE,  D},
        {C_RF,     5'd1,  6'd2,  A_NONE,  D},
        {C_FH,     5'd1,  6'd2,  A_NONE,  16'd1},
        {C_FT,     5'd1,  6'd2,  A_NONE,  D},
        {C_RUN,    5'd1,  6'd2,  A_NONE,  16'd0}
    };

    logic clk = 1'b0;
    logic rst_n, sys_reset_n, pll_pwr_ok, core_pwr_ok, pwr_good, fwd_rst;
    logic init_done, test_done, sleep_req, irq, fault;
    logic [3:0] seq_state;
    logic [4:0] div_x;
    logic [5:0] div_z;
    logic init_start, init_run, test_start, test_run;

    int checks = 0;
    int errors = 0;
    int n_init = 0;
    int n_test = 0;

    always #4 clk = ~clk;

    pwrup_seq #(.DWELL(DWELL)) uut (
        .clk(clk), .rst_n(rst_n), .sys_reset_n(sys_reset_n), .pll_pwr_ok(pll_pwr_ok),
        .core_pwr_ok(core_pwr_ok), .pwr_good(pwr_good), .fwd_rst(fwd_rst),
        .init_done(init_done), .test_done(test_done), .sleep_req(sleep_req),
        .irq(irq), .fault(fault), .seq_state(seq_state), .div_x(div_x), .div_z(div_z),
        .init_start(init_start), .init_run(init_run), .test_start(test_start),
        .test_run(test_run));

    always @(negedge clk) begin
        if (rst_n && init_start) n_init++;
        if (rst_n && test_start) n_test++;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [3:0] st, input logic [3:0] prev);
        if (prev == C_IRQW || prev == C_RSTW) return "R9";
        if (prev == C_FLT || (st == C_FH && prev == C_RF)) return "R10";
        case (st)
            C_COLD, C_SETTLE:        return "R2";
            C_NOM, C_RS, C_RF:       return "R4";
            C_INIT, C_TEST:          return "R5";
            C_FH, C_FT:              return "R6";
            C_IRQW, C_RSTW:          return "R8";
            C_FLT:                   return "R10";
            default:                 return "R7";
        endcase
    endfunction

    task automatic apply(input logic [3:0] a);
        case (a)
            A_PWR:    begin pll_pwr_ok = 1'b1; core_pwr_ok = 1'b1; end
            A_PG:     pwr_good = 1'b1;
            A_RELS:   sys_reset_n = 1'b1;
            A_INIT:   init_done = 1'b1;
            A_TEST:   test_done = 1'b1;
            A_FWD:    fwd_rst = 1'b0;
            A_SLEEP:  sleep_req = 1'b1;
            A_IRQ:    begin sleep_req = 1'b0; irq = 1'b1; end
            A_RSTDN:  begin sys_reset_n = 1'b0; sleep_req = 1'b0; end
            A_FLT:    fault = 1'b1;
            A_FLTCLR: fault = 1'b0;
            default:  ;
        endcase
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", seq_state, C_RUN);
        finish_run();
    end

    initial begin
        logic [3:0] prev_st;
        rst_n = 1'b0; sys_reset_n = 1'b0; pll_pwr_ok = 1'b1; core_pwr_ok = 1'b1;
        pwr_good = 1'b0; fwd_rst = 1'b1; init_done = 1'b0; test_done = 1'b0;
        sleep_req = 1'b0; irq = 1'b0; fault = 1'b0;
        repeat (4) @(negedge clk);
        // R1: reset state, even with supplies present
        chk(seq_state == C_COLD, "R1", "state in reset", seq_state, C_COLD);
        chk(div_x == 16 && div_z == 32, "R1", "div_x in reset", div_x, 16);
        chk({init_start, init_run, test_start, test_run} == 4'b0, "R1", "phase outputs",
            {init_start, init_run, test_start, test_run}, 0);
        pll_pwr_ok = 1'b0; core_pwr_ok = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(seq_state == C_COLD, "R1", "state after release", seq_state, C_COLD);

        prev_st = C_COLD;
        for (int i = 0; i < NE; i++) begin
            logic [3:0]  st, act;
            logic [4:0]  dx;
            logic [5:0]  dz;
            logic [15:0] n;
            int          cnt;
            string       rq;
            {st, dx, dz, act, n} = TBL[i];
            rq = req_of(st, prev_st);
            chk(seq_state == st, rq, $sformatf("state at step %0d", i), seq_state, st);
            chk(div_x == dx && div_z == dz, "R3", $sformatf("div_x*64+div_z at step %0d", i),
                div_x * 64 + div_z, dx * 64 + dz);
            if (st == C_INIT)
                chk(init_start && init_run && !test_run, "R5", "init pulse/run",
                    {init_start, init_run}, 3);
            if (st == C_TEST)
                chk(test_start && test_run && !init_run, "R5", "test pulse/run",
                    {test_start, test_run}, 3);
            apply(act);
            if (n != 0) begin
                cnt = 1;
                @(negedge clk);
                init_done = 1'b0; test_done = 1'b0; irq = 1'b0;
                while (seq_state == st && cnt < DWELL + 8) begin
                    cnt++;
                    @(negedge clk);
                end
                chk(cnt == int'(n), rq, $sformatf("cycles in state %0d", st), cnt, n);
            end
            prev_st = st;
        end

        // R5 R10: self-test pulses only on the two normal ramps plus the first
        chk(n_init == 3, "R10", "init_start pulse count", n_init, 3);
        chk(n_test == 3, "R10", "test_start pulse count", n_test, 3);

        // R11: supply loss from run forces cold on the next edge
        core_pwr_ok = 1'b0;
        @(negedge clk);
        chk(seq_state == C_COLD, "R11", "state after supply loss", seq_state, C_COLD);
        chk(div_x == 16 && div_z == 32, "R11", "div_x after supply loss", div_x, 16);

        // R12: with a supply missing, other inputs have no effect in cold
        irq = 1'b1; init_done = 1'b1; test_done = 1'b1; sleep_req = 1'b1;
        fault = 1'b1; fwd_rst = 1'b1; sys_reset_n = 1'b0;
        repeat (6) @(negedge clk);
        chk(seq_state == C_COLD, "R12", "state with inputs toggled", seq_state, C_COLD);
        chk(div_x == 16 && div_z == 32, "R12", "div_x held", div_x, 16);
        chk(!init_start && !test_start && !init_run && !test_run, "R12", "phase outputs",
            {init_start, test_start, init_run, test_run}, 0);

        // R2: supplies return with the chip reset asserted -> settle next edge
        irq = 1'b0; init_done = 1'b0; test_done = 1'b0; sleep_req = 1'b0; fault = 1'b0;
        core_pwr_ok = 1'b1;
        @(negedge clk);
        chk(seq_state == C_SETTLE, "R2", "state after supplies return", seq_state, C_SETTLE);
        finish_run();
    end
endmodule